// File: doc/BRIEF.md
# Adaptive EPROM Programming Sequencer

This controller sits on the programmer side of a parallel, byte-wide, UV-erasable memory and burns a byte image into it. After a start request it steps through the address space from the lowest location to the highest. For each location it fetches the wanted byte from an image source that is indexed by address. It reads the cell back and gives it fixed-width program pulses, re-reading after every pulse. It moves on only when the byte compares equal. A location fails when a per-address pulse cap is reached, or when a wanted 1 sits over a cell bit that already reads 0, because programming can only clear bits.

While pulsing, the sequencer holds the supply-select output at the raised level. Once the last location is done it drops the supply to the nominal level and reads every location back a second time. It reports either a one-cycle completion strobe or a sticky error flag together with the address that failed. Pulse width is given in microseconds and converted to clock cycles from a clock-frequency parameter. The read-back settle time is a separate cycle count. The default build covers 65,536 byte locations.

Top module: `eprom_prog_seq`

## Requirements
- R1: While reset is high, and afterwards until start is seen, busy, done and error are 0, mem_ce_n and mem_oe_n are 1, mem_vpp_on and mem_drive are 0, and vcc_hi is 0.
- R2: A start seen while idle makes busy 1 on the following cycle. vcc_hi is 1 whenever a program pulse is applied.
- R3: A program pulse drives mem_vpp_on=1, mem_drive=1, mem_ce_n=0 and mem_oe_n=1 for exactly PULSE_CYC = (CLK_HZ/1000)*PULSE_US/1000 consecutive cycles. During the pulse, mem_addr and mem_wdata hold the location and its target byte.
- R4: A read-back drives mem_ce_n=0, mem_oe_n=0 and mem_vpp_on=0, and samples mem_rdata at the end of the ACC_CYC-th cycle of that read window.
- R5: Locations are handled in ascending order. Each location gets a read before any pulse and a read after every pulse, and it receives pulses only while the read-back differs from the target. When the run succeeds, every location holds its target.
- R6: A location whose target is all ones (8'hFF for 8-bit data) receives no pulse.
- R7: If the read-back has a 0 in any bit where the target has a 1, the run ends with error=1, busy=0 and err_addr equal to that location, and that location receives no further pulse.
- R8: If a location still differs after MAX_PULSES pulses, the run ends with error=1, busy=0 and err_addr equal to that location.
- R9: After the pulse phase, every location is read again with vcc_hi=0. The first location that differs from its target ends the run with error=1 and err_addr set to it.
- R10: A run with no failure ends with done=1 for exactly one cycle, in the same cycle that busy first reads 0. error stays 0.
- R11: mem_vpp_on is never 1 while mem_oe_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a programming run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle success strobe |
| error | output | 1 | Sticky failure flag, cleared by the next start |
| err_addr | output | ADDR_W | Location that caused the failure |
| src_addr | output | ADDR_W | Address into the image source |
| src_data | input | DATA_W | Target byte for src_addr, valid in the same cycle |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_wdata | output | DATA_W | Data driven to the memory during a pulse |
| mem_drive | output | 1 | Programmer drives the data lines |
| mem_rdata | input | DATA_W | Data read from the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_vpp_on | output | 1 | Program voltage applied on the enable/program pin |
| vcc_hi | output | 1 | Supply select: 1 raised, 0 nominal |

## Verification
The bench models a memory cell array in which each location needs a chosen number of pulses before its zero bits appear. The model returns filler data until a read window has lasted the access count, so a sample taken too early turns into a wrong outcome. Random images mix all-ones targets with random pulse needs, which separates correct adaptive pulse counts from fixed counts, skipped locations and early sampling. Several directed images each isolate one ending: cells already programmed that must get no pulse, a location needing one pulse more than the cap, a location already holding a 0 under a wanted 1, and a bit that reverts to 1 between the two phases and is caught only by the nominal-supply pass.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PFETCH,
        ST_PREAD,
        ST_PEVAL,
        ST_PULSE,
        ST_VFETCH,
        ST_VREAD,
        ST_VEVAL
    } seq_state_e;

    typedef enum logic [1:0] {
        JD_MATCH,
        JD_PULSE,
        JD_STUCK
    } judge_e;

    function automatic int cycles_for_us(input int hz, input int us);
        return (hz / 1000) * us / 1000;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eprom_delay_timer.sv
module eprom_delay_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R3, R4: an idle timer stays at zero until reloaded
    a_r3_timer_rest: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && $past(cnt_q) == '0) |-> cnt_q == '0);

endmodule

// File: rtl/eprom_byte_judge.sv
module eprom_byte_judge
    import eprom_prog_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] want,
    input  logic [W-1:0] seen,
    output judge_e       verdict
);
    logic stuck_bits;

    assign stuck_bits = |(want & ~seen);

    always_comb begin
        if (stuck_bits)        verdict = JD_STUCK;
        else if (want == seen) verdict = JD_MATCH;
        else                   verdict = JD_PULSE;
    end

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
    import eprom_prog_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int CLK_HZ     = 50_000_000,
    parameter int PULSE_US   = 100,
    parameter int ACC_CYC    = 4,
    parameter int MAX_PULSES = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [ADDR_W-1:0] err_addr,
    output logic [ADDR_W-1:0] src_addr,
    input  logic [DATA_W-1:0] src_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_drive,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_vpp_on,
    output logic              vcc_hi
);
    localparam int PULSE_CYC = cycles_for_us(CLK_HZ, PULSE_US);
    localparam int TW        = $clog2(max2(PULSE_CYC, ACC_CYC) + 1);
    localparam int PCW       = $clog2(MAX_PULSES + 1);
    localparam logic [TW-1:0]     PULSE_LD = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0]     ACC_LD   = TW'(ACC_CYC - 1);
    localparam logic [PCW-1:0]    PCAP     = PCW'(MAX_PULSES);
    localparam logic [ADDR_W-1:0] LAST_A   = {ADDR_W{1'b1}};
    localparam logic [DATA_W-1:0] BLANK    = {DATA_W{1'b1}};

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] tgt_q, rb_q;
    logic [PCW-1:0]    pcnt_q;
    judge_e            verdict;

    logic tmr_load, tmr_exp;
    logic [TW-1:0] tmr_val;
    logic go, cap_tgt, cap_rb, pcnt_clr, pcnt_inc, adv, fail, finish;
    logic at_last;

    eprom_delay_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    eprom_byte_judge #(.W(DATA_W)) u_judge (
        .want    (tgt_q),
        .seen    (rb_q),
        .verdict (verdict)
    );

    assign at_last = (addr_q == LAST_A);

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = ACC_LD;
        go       = 1'b0;
        cap_tgt  = 1'b0;
        cap_rb   = 1'b0;
        pcnt_clr = 1'b0;
        pcnt_inc = 1'b0;
        adv      = 1'b0;
        fail     = 1'b0;
        finish   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    go      = 1'b1;
                    state_d = ST_PFETCH;
                end
            end
            ST_PFETCH: begin
                cap_tgt = 1'b1;
                if (src_data == BLANK) begin
                    adv     = 1'b1;
                    state_d = at_last ? ST_VFETCH : ST_PFETCH;
                end else begin
                    pcnt_clr = 1'b1;
                    tmr_load = 1'b1;
                    state_d  = ST_PREAD;
                end
            end
            ST_PREAD: begin
                if (tmr_exp) begin
                    cap_rb  = 1'b1;
                    state_d = ST_PEVAL;
                end
            end
            ST_PEVAL: begin
                case (verdict)
                    JD_STUCK: begin
                        fail    = 1'b1;
                        state_d = ST_IDLE;
                    end
                    JD_MATCH: begin
                        adv     = 1'b1;
                        state_d = at_last ? ST_VFETCH : ST_PFETCH;
                    end
                    default: begin
                        if (pcnt_q == PCAP) begin
                            fail    = 1'b1;
                            state_d = ST_IDLE;
                        end else begin
                            pcnt_inc = 1'b1;
                            tmr_load = 1'b1;
                            tmr_val  = PULSE_LD;
                            state_d  = ST_PULSE;
                        end
                    end
                endcase
            end
            ST_PULSE: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    state_d  = ST_PREAD;
                end
            end
            ST_VFETCH: begin
                cap_tgt  = 1'b1;
                tmr_load = 1'b1;
                state_d  = ST_VREAD;
            end
            ST_VREAD: begin
                if (tmr_exp) begin
                    cap_rb  = 1'b1;
                    state_d = ST_VEVAL;
                end
            end
            ST_VEVAL: begin
                if (verdict != JD_MATCH) begin
                    fail    = 1'b1;
                    state_d = ST_IDLE;
                end else if (at_last) begin
                    finish  = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    adv     = 1'b1;
                    state_d = ST_VFETCH;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            tgt_q    <= '0;
            rb_q     <= '0;
            pcnt_q   <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
            error    <= 1'b0;
            err_addr <= '0;
        end else begin
            state_q <= state_d;
            done    <= 1'b0;
            if (go) begin
                busy   <= 1'b1;
                error  <= 1'b0;
                addr_q <= '0;
            end
            if (cap_tgt) tgt_q <= src_data;
            if (cap_rb)  rb_q  <= mem_rdata;
            if (pcnt_clr)      pcnt_q <= '0;
            else if (pcnt_inc) pcnt_q <= pcnt_q + 1'b1;
            if (adv) addr_q <= addr_q + 1'b1;
            if (fail) begin
                error    <= 1'b1;
                err_addr <= addr_q;
                busy     <= 1'b0;
            end
            if (finish) begin
                done <= 1'b1;
                busy <= 1'b0;
            end
        end
    end

    assign src_addr   = addr_q;
    assign mem_addr   = addr_q;
    assign mem_wdata  = tgt_q;
    assign mem_drive  = (state_q == ST_PULSE);
    assign mem_vpp_on = (state_q == ST_PULSE);
    assign mem_ce_n   = !(state_q inside {ST_PREAD, ST_PULSE, ST_VREAD});
    assign mem_oe_n   = !(state_q inside {ST_PREAD, ST_VREAD});
    assign vcc_hi     = state_q inside {ST_PFETCH, ST_PREAD, ST_PEVAL, ST_PULSE};

    a_r11_vpp_oe_excl: assert property (@(posedge clk) disable iff (rst)
        mem_vpp_on |-> mem_oe_n);

    a_r3_pulse_ctrl: assert property (@(posedge clk) disable iff (rst)
        mem_vpp_on |-> (!mem_ce_n && vcc_hi && busy));

    a_r3_pulse_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_vpp_on && $past(mem_vpp_on)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

    a_r10_done_once: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !error));

    a_r8_pulse_cap: assert property (@(posedge clk) disable iff (rst)
        busy |-> (pcnt_q <= PCAP));

    a_r7_stuck_stop: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PEVAL && verdict == JD_STUCK) |=> (error && !busy && err_addr == $past(addr_q)));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mem_ce_n && !mem_vpp_on && !vcc_hi));

endmodule

// File: tb/sim_eprom_prog_seq.sv
`timescale 1ns/1ps
module sim_eprom_prog_seq;
    localparam int AW   = 4;
    localparam int N    = 16;
    localparam int ACC  = 3;
    localparam int MAXP = 4;
    localparam int PCYC = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done, error, mem_drive, mem_ce_n, mem_oe_n, mem_vpp_on, vcc_hi;
    logic [AW-1:0] err_addr, src_addr, mem_addr;
    logic [7:0] src_data, mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;

    logic [7:0] img [N];
    logic [7:0] mem [N];
    logic [7:0] init_m [N];
    logic [7:0] fin [N];
    int need [N];
    int pc [N];
    int exp_pc [N];
    int exp_ok, exp_ea;
    int decay_en, decay_a;
    logic [7:0] decay_mask;

    int age, plen, pa, last_pa, order_bad, pulse_bad, ctl_bad, vreads;
    logic [7:0] pdat;
    logic prev_vcc;

    always #10 clk = ~clk;

    eprom_prog_seq #(
        .ADDR_W(AW), .DATA_W(8), .CLK_HZ(100_000), .PULSE_US(100),
        .ACC_CYC(ACC), .MAX_PULSES(MAXP)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .error(error), .err_addr(err_addr), .src_addr(src_addr),
        .src_data(src_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_drive(mem_drive), .mem_rdata(mem_rdata), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_vpp_on(mem_vpp_on), .vcc_hi(vcc_hi)
    );

    assign src_data  = img[src_addr];
    assign mem_rdata = (!mem_ce_n && !mem_oe_n && age >= ACC) ? mem[mem_addr] : 8'h5A;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory cell model: each location needs need[] pulses before its zeros appear
    always @(negedge clk) begin
        if (rst) begin
            age = 0;
            plen = 0;
            prev_vcc = 1'b0;
        end else begin
            if (!mem_ce_n && !mem_oe_n) age++;
            else age = 0;
            if (mem_vpp_on && !mem_oe_n) ctl_bad++;          // R11
            if (mem_vpp_on && !mem_ce_n) begin
                if (plen == 0) begin
                    if (int'(mem_addr) < last_pa) order_bad++;  // R5 ascending
                    pa = int'(mem_addr);
                    last_pa = pa;
                    pdat = mem_wdata;
                end
                plen++;
                if (!vcc_hi || !mem_drive || !mem_oe_n || mem_wdata != img[pa] || int'(mem_addr) != pa)
                    ctl_bad++;                                 // R2, R3
            end else if (plen > 0) begin
                if (plen != PCYC) pulse_bad++;                 // R3 width
                pc[pa]++;
                if (pc[pa] >= need[pa]) mem[pa] = mem[pa] & pdat;
                plen = 0;
            end
            if (prev_vcc && !vcc_hi && decay_en != 0) mem[decay_a] = mem[decay_a] | decay_mask;
            prev_vcc = vcc_hi;
            if (!mem_ce_n && !mem_oe_n && age == 1 && !vcc_hi) vreads++;
        end
    end

    task automatic predict();
        int stopped;
        exp_ok = 1;
        exp_ea = 0;
        stopped = 0;
        for (int a = 0; a < N; a++) begin
            exp_pc[a] = 0;
            fin[a] = init_m[a];
        end
        for (int a = 0; a < N && stopped == 0; a++) begin
            logic [7:0] rb;
            if (img[a] == 8'hFF) continue;
            rb = init_m[a];
            forever begin
                if ((img[a] & ~rb) != 8'h00) begin
                    exp_ok = 0; exp_ea = a; stopped = 1; break;
                end
                if (rb == img[a]) break;
                if (exp_pc[a] == MAXP) begin
                    exp_ok = 0; exp_ea = a; stopped = 1; break;
                end
                exp_pc[a]++;
                if (exp_pc[a] >= need[a]) rb = rb & img[a];
            end
            fin[a] = rb;
        end
        if (stopped == 0) begin
            if (decay_en != 0) fin[decay_a] = fin[decay_a] | decay_mask;
            for (int a = 0; a < N; a++) begin
                if (fin[a] != img[a]) begin
                    exp_ok = 0; exp_ea = a; break;
                end
            end
        end
    endtask

    task automatic run_case(input string name);
        int cnt_bad, ff_bad, mem_bad, wait_n;
        for (int a = 0; a < N; a++) begin
            mem[a] = init_m[a];
            pc[a] = 0;
        end
        last_pa = 0; order_bad = 0; pulse_bad = 0; ctl_bad = 0; vreads = 0;
        predict();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {"R2 busy after start ", name}, busy, 1);
        wait_n = 0;
        while (busy && wait_n < 20000) begin
            @(negedge clk);
            wait_n++;
        end
        // R4: early sampling returns filler data and changes this outcome
        chk(done == exp_ok[0], {"R10 done at end ", name}, done, exp_ok);
        chk(error == !exp_ok[0], {"R7 R8 R9 error flag ", name}, error, !exp_ok[0]);
        if (exp_ok == 0)
            chk(int'(err_addr) == exp_ea, {"R7 R8 R9 err_addr ", name}, err_addr, exp_ea);
        cnt_bad = 0; ff_bad = 0; mem_bad = 0;
        for (int a = 0; a < N; a++) begin
            if (pc[a] != exp_pc[a]) cnt_bad++;
            if (img[a] == 8'hFF && pc[a] != 0) ff_bad++;
            if (fin[a] != mem[a]) mem_bad++;
        end
        chk(cnt_bad == 0, {"R5 per-address pulse counts ", name}, cnt_bad, 0);
        chk(ff_bad == 0, {"R6 no pulse on blank targets ", name}, ff_bad, 0);
        chk(order_bad == 0, {"R5 ascending order ", name}, order_bad, 0);
        chk(pulse_bad == 0, {"R3 pulse width ", name}, pulse_bad, 0);
        chk(ctl_bad == 0, {"R3 R11 pulse controls ", name}, ctl_bad, 0);
        if (exp_ok != 0) begin
            chk(mem_bad == 0, {"R5 final memory ", name}, mem_bad, 0);
            chk(vreads == N, {"R9 nominal verify reads ", name}, vreads, N);
        end
        @(negedge clk);
        chk(done == 1'b0, {"R10 done one cycle ", name}, done, 0);
        chk(busy == 1'b0 && mem_ce_n, {"R1 idle after run ", name}, busy, 0);
    endtask

    task automatic blank_setup();
        for (int a = 0; a < N; a++) begin
            img[a] = 8'hFF;
            init_m[a] = 8'hFF;
            need[a] = 1;
        end
        decay_en = 0;
        decay_a = 0;
        decay_mask = 8'h00;
    endtask

    task automatic random_img();
        for (int a = 0; a < N; a++) begin
            img[a] = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom);
            need[a] = 1 + int'($urandom % MAXP);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        blank_setup();
        repeat (3) @(negedge clk);
        chk(!busy && !done && !error && mem_ce_n && mem_oe_n && !mem_vpp_on && !vcc_hi && !mem_drive,
            "R1 outputs in reset", busy, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !error && mem_ce_n && mem_oe_n && !mem_vpp_on && !vcc_hi,
            "R1 outputs after reset", busy, 0);

        blank_setup();
        run_case("all blank");

        for (int k = 0; k < 4; k++) begin
            blank_setup();
            random_img();
            run_case("random");
        end

        blank_setup();
        random_img();
        for (int a = 0; a < N; a += 2) init_m[a] = img[a];
        run_case("partly preprogrammed");

        blank_setup();
        random_img();
        for (int a = 0; a < 7; a++) need[a] = 1 + (a % MAXP);
        img[7] = 8'h3C;
        need[7] = MAXP + 1;
        run_case("R8 pulse cap");

        blank_setup();
        random_img();
        init_m[9] = 8'hF0;
        img[9] = 8'h0F;
        run_case("R7 stuck zero");

        blank_setup();
        random_img();
        img[11] = 8'h81;
        decay_en = 1;
        decay_a = 11;
        decay_mask = 8'h02;
        run_case("R9 verify mismatch");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule